// File: doc/BRIEF.md
# Scan Session Weighted Transition Counter

This block measures the shift-power cost of one scan load/unload. While a scan chain of `SCAN_LEN` cells shifts, the bench or tester feeds the block one pair per shift: the bit entering the chain (test vector) and the bit leaving it (previous response). The block adds up every transition between neighbouring bits, and each transition is weighted by the number of shifts that put it on the cell outputs. When the last pair of the session has arrived, the block gives the total and raises a one-cycle completion pulse.

Number the cells 1..L, with L = `SCAN_LEN`. Bits enter and leave highest index first: the first pair of a session carries test bit L and response bit L, and the last pair carries bit 1 of each. The total is L·(t1 XOR r1), plus i·(t_i XOR t_{i+1}) summed over i = 1..L−1, plus (L−i)·(r_i XOR r_{i+1}) over the same range. The highest possible total is L². The pair interface has no back-pressure. The block accepts a pair in every cycle in which `pair_valid_i` is high during a session, so it can follow a chain that shifts in every clock cycle. A session starts with `start_i`. Once the L-th pair has been counted, the block ignores further pairs until the next start.

Top module: `wtc_accumulator`

## Requirements
- R1: After reset, `wtc_o` is 0 and `done_o` is 0.
- R2: While no session is open (after reset and before the first `start_i`), pairs presented with `pair_valid_i` high do not change `wtc_o` and do not raise `done_o`.
- R3: After L accepted pairs, `wtc_o` equals L·(t1^r1) + Σ i·(t_i^t_{i+1}) + Σ (L−i)·(r_i^r_{i+1}), with i from 1 to L−1.
- R4: `done_o` is high for exactly the one cycle that follows the clock edge that accepts the L-th pair. That edge also updates `wtc_o` to the final total.
- R5: After a session completes, `wtc_o` holds its value and pairs are ignored until the next `start_i`.
- R6: `start_i` clears the running total. If `pair_valid_i` is high in the same cycle, that pair is the first pair of the new session. If it is low, the next valid pair is the first pair.
- R7: A `start_i` in the middle of a session drops the partial sum and the position, and the session begins again.
- R8: The first pair of a session is cell L. A test vector with only t_L = 1 and an all-zero response gives L−1.
- R9: The total never exceeds L². Alternating vectors with t1 ≠ r1 reach exactly L².
- R10: Cycles with `pair_valid_i` low between pairs do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new session and clears the total |
| pair_valid_i | input | 1 | A scan pair is present this cycle |
| scan_in_i | input | 1 | Test bit entering the chain |
| scan_out_i | input | 1 | Response bit leaving the chain |
| wtc_o | output | $clog2(2·L²+1) | Running and final weighted transition count |
| done_o | output | 1 | One-cycle pulse when the session's total is final |

## Verification
The assertions assume that `SCAN_LEN` is at least 2, and that a new session does not start before the previous one has delivered its L pairs, unless the caller means to abort it. Under those assumptions the completion pulse cannot repeat on consecutive cycles, and the total cannot decrease between start strobes. The stimulus always sends full sessions, with one deliberate abort. Start strobes are driven only on a session's first pair or on an idle cycle. Idle gaps only ever stretch a session and never cut it short, so every input the bench drives stays within these assumptions.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  // Width that holds 2*L*L without overflow
  function automatic int wtc_cnt_width(input int len);
    return $clog2(2 * len * len + 1);
  endfunction

  function automatic int wtc_idx_width(input int len);
    return (len > 2) ? $clog2(len) : 1;
  endfunction

endpackage

// File: rtl/wtc_pos_ctr.sv
module wtc_pos_ctr #(
  parameter int SCAN_LEN = 16,
  parameter int IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             valid,
  output logic             step,
  output logic [IDX_W-1:0] cur_idx,
  output logic             is_last,
  output logic             active
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SCAN_LEN - 1);

  logic [IDX_W-1:0] idx_q;

  // A start restarts the position, even in the same cycle as a pair
  assign cur_idx = start ? '0 : idx_q;
  assign step    = valid && (active || start);
  assign is_last = step && (cur_idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx_q  <= '0;
    end else if (step) begin
      active <= !is_last;
      idx_q  <= is_last ? '0 : cur_idx + 1'b1;
    end else if (start) begin
      active <= 1'b1;
      idx_q  <= '0;
    end
  end

endmodule

// File: rtl/wtc_term_gen.sv
module wtc_term_gen #(
  parameter int SCAN_LEN = 16,
  parameter int IDX_W    = 4,
  parameter int CNT_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic             is_last,
  input  logic             scan_in,
  input  logic             scan_out,
  output logic [CNT_W-1:0] term
);

  localparam logic [CNT_W-1:0] LEN_C = CNT_W'(SCAN_LEN);

  logic             prev_in_q, prev_out_q;
  logic             has_prev;
  logic [CNT_W-1:0] pos_c, in_wt, out_wt, bnd_wt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_in_q  <= 1'b0;
      prev_out_q <= 1'b0;
    end else if (step) begin
      prev_in_q  <= scan_in;
      prev_out_q <= scan_out;
    end
  end

  // Pair k carries cell index L-k: its scan-in edge weighs L-k and its scan-out edge weighs k
  always_comb begin
    pos_c    = CNT_W'(cur_idx);
    has_prev = (cur_idx != '0);
    in_wt    = (has_prev && (scan_in  ^ prev_in_q))  ? (LEN_C - pos_c) : '0;
    out_wt   = (has_prev && (scan_out ^ prev_out_q)) ? pos_c : '0;
    bnd_wt   = (is_last && (scan_in ^ scan_out)) ? LEN_C : '0;
    term     = in_wt + out_wt + bnd_wt;
  end

endmodule

// File: rtl/wtc_sum_reg.sv
module wtc_sum_reg #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic             is_last,
  input  logic [CNT_W-1:0] term,
  output logic [CNT_W-1:0] total,
  output logic             done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total <= '0;
      done  <= 1'b0;
    end else begin
      done <= is_last;
      if (start)
        total <= step ? term : '0;
      else if (step)
        total <= total + term;
    end
  end

endmodule

// File: rtl/wtc_accumulator.sv
module wtc_accumulator #(
  parameter int SCAN_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic pair_valid_i,
  input  logic scan_in_i,
  input  logic scan_out_i,
  output logic [wtc_pkg::wtc_cnt_width(SCAN_LEN)-1:0] wtc_o,
  output logic done_o
);

  localparam int CNT_W = wtc_pkg::wtc_cnt_width(SCAN_LEN);
  localparam int IDX_W = wtc_pkg::wtc_idx_width(SCAN_LEN);

  logic             step;
  logic             is_last;
  logic             sess_active;
  logic [IDX_W-1:0] cur_idx;
  logic [CNT_W-1:0] term;

  wtc_pos_ctr #(.SCAN_LEN(SCAN_LEN), .IDX_W(IDX_W)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_i),
    .valid   (pair_valid_i),
    .step    (step),
    .cur_idx (cur_idx),
    .is_last (is_last),
    .active  (sess_active)
  );

  wtc_term_gen #(.SCAN_LEN(SCAN_LEN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_term (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .cur_idx  (cur_idx),
    .is_last  (is_last),
    .scan_in  (scan_in_i),
    .scan_out (scan_out_i),
    .term     (term)
  );

  wtc_sum_reg #(.CNT_W(CNT_W)) u_sum (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_i),
    .step    (step),
    .is_last (is_last),
    .term    (term),
    .total   (wtc_o),
    .done    (done_o)
  );

endmodule

// File: rtl/wtc_accumulator_chk.sv
module wtc_accumulator_chk #(
  parameter int SCAN_LEN = 16
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic valid,
  input logic active,
  input logic [wtc_pkg::wtc_cnt_width(SCAN_LEN)-1:0] total,
  input logic done
);

  localparam int CNT_W = wtc_pkg::wtc_cnt_width(SCAN_LEN);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(SCAN_LEN * SCAN_LEN);

  always @(posedge clk) begin
    if (rst_n) begin
      AST_NO_OVERFLOW: assert (total <= MAX_C); // R9
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4

  AST_DONE_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(valid)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !(valid && active)) |=> $stable(total)); // R5

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !valid) |=> (total == '0)); // R6

  AST_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (total >= $past(total))); // R3

endmodule

bind wtc_accumulator wtc_accumulator_chk #(.SCAN_LEN(SCAN_LEN)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start_i),
  .valid  (pair_valid_i),
  .active (sess_active),
  .total  (wtc_o),
  .done   (done_o)
);

// File: tb/wtc_accumulator_bench.sv
module wtc_accumulator_bench;

  localparam int L = 4;
  localparam int CW = wtc_pkg::wtc_cnt_width(L);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic pair_valid_i = 1'b0;
  logic scan_in_i = 1'b0;
  logic scan_out_i = 1'b0;
  logic [CW-1:0] wtc_o;
  logic done_o;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  wtc_accumulator #(.SCAN_LEN(L)) u_wtc_accumulator (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .pair_valid_i (pair_valid_i),
    .scan_in_i    (scan_in_i),
    .scan_out_i   (scan_out_i),
    .wtc_o        (wtc_o),
    .done_o       (done_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // Bit i-1 of a vector holds cell i
  function automatic int model(input logic [L-1:0] tv, input logic [L-1:0] rv);
    int w;
    w = L * int'(tv[0] ^ rv[0]);
    for (int i = 1; i < L; i++)
      w += i * int'(tv[i-1] ^ tv[i]) + (L - i) * int'(rv[i-1] ^ rv[i]);
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_session(input logic [L-1:0] tv, input logic [L-1:0] rv,
                             input bit gaps, input bit with_start);
    for (int k = 0; k < L; k++) begin
      if (gaps && k != 0 && ($urandom % 2 == 1)) begin
        start_i = 1'b0;
        pair_valid_i = 1'b0;
        scan_in_i = 1'($urandom);
        scan_out_i = 1'($urandom);
        @(negedge clk);
      end
      start_i = (k == 0) && with_start;
      pair_valid_i = 1'b1;
      scan_in_i = tv[L-1-k];
      scan_out_i = rv[L-1-k];
      @(negedge clk);
    end
    start_i = 1'b0;
    pair_valid_i = 1'b0;
  endtask

  initial begin
    int held;
    int exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(wtc_o == 0, "R1 count", int'(wtc_o), 0);
    check(done_o == 1'b0, "R1 done", int'(done_o), 0);

    // R2: pairs before any start
    for (int c = 0; c < 3; c++) begin
      pair_valid_i = 1'b1;
      scan_in_i = c[0];
      scan_out_i = ~c[0];
      @(negedge clk);
    end
    pair_valid_i = 1'b0;
    check(wtc_o == 0, "R2 count", int'(wtc_o), 0);
    check(done_o == 1'b0, "R2 done", int'(done_o), 0);

    // R3/R4/R10: every pair of vectors, some with idle gaps
    for (int a = 0; a < (1 << L); a++) begin
      for (int b = 0; b < (1 << L); b++) begin
        exp = model(L'(a), L'(b));
        run_session(L'(a), L'(b), ((a + b) % 3 == 0), 1'b1);
        check(int'(wtc_o) == exp, "R3 total", int'(wtc_o), exp);
        check(done_o == 1'b1, "R4 done high", int'(done_o), 1);
        held = int'(wtc_o);
        @(negedge clk);
        check(done_o == 1'b0, "R4 done single", int'(done_o), 0);
        check(int'(wtc_o) == held, "R5 hold", int'(wtc_o), held);
      end
    end

    // R5: pairs after completion are ignored
    held = int'(wtc_o);
    for (int c = 0; c < 3; c++) begin
      pair_valid_i = 1'b1;
      scan_in_i = c[0];
      scan_out_i = c[1];
      @(negedge clk);
      check(done_o == 1'b0, "R5 no done", int'(done_o), 0);
    end
    pair_valid_i = 1'b0;
    check(int'(wtc_o) == held, "R5 ignored", int'(wtc_o), held);

    // R6: start alone clears, next pair is the first
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(wtc_o == 0, "R6 clear", int'(wtc_o), 0);
    exp = model(4'b0110, 4'b1001);
    run_session(4'b0110, 4'b1001, 1'b0, 1'b0);
    check(int'(wtc_o) == exp, "R6 session", int'(wtc_o), exp);

    // R7: abort after two pairs, restart
    start_i = 1'b1; pair_valid_i = 1'b1; scan_in_i = 1'b1; scan_out_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0; scan_in_i = 1'b0; scan_out_i = 1'b1;
    @(negedge clk);
    pair_valid_i = 1'b0;
    exp = model(4'b0011, 4'b0101);
    run_session(4'b0011, 4'b0101, 1'b0, 1'b1);
    check(int'(wtc_o) == exp, "R7 restart", int'(wtc_o), exp);
    check(done_o == 1'b1, "R7 done", int'(done_o), 1);

    // R8: only cell L set in the test vector
    run_session(4'b1000, 4'b0000, 1'b0, 1'b1);
    check(int'(wtc_o) == L - 1, "R8 order", int'(wtc_o), L - 1);

    // R9: the largest total
    run_session(4'b0101, 4'b1010, 1'b0, 1'b1);
    check(int'(wtc_o) == L * L, "R9 max", int'(wtc_o), L * L);

    // R10: the same vector with and without gaps
    run_session(4'b1101, 4'b0010, 1'b0, 1'b1);
    held = int'(wtc_o);
    run_session(4'b1101, 4'b0010, 1'b1, 1'b1);
    check(int'(wtc_o) == held, "R10 gaps", int'(wtc_o), held);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule